// File: doc/BRIEF.md
# Segment Base-and-Limit Address Translator

This block turns logical addresses into physical ones for two independent request streams: the instruction-fetch stream, which carries program-counter addresses, and the data stream, which carries load and store addresses. Each stream has its own relocation base and its own segment length. The block adds the stream's base to the incoming logical address to form the physical address. In parallel, it compares the logical address against the segment length and marks the access as faulting when the address falls outside the segment.

The four segment registers are loaded through one configuration port, and a load takes effect only while the supervisor-mode input is high. A load attempted in user mode leaves every register unchanged and raises a one-cycle error pulse. Translation is combinational from the inputs and lands in an output register. A request presented in one cycle therefore has its result on the outputs after the next rising edge. When an access faults, the physical address is still presented, but the OK flag stays low and the fault flag goes high.

Top module: `seg_translator`

## Requirements
- R1: After a synchronous active-low reset, all outputs are low and every segment register is zero, so any request faults until the segments are loaded.
- R2: For a request in cycle N, the physical-address output after edge N+1 equals base + logical address, modulo 2^AW.
- R3: A request faults exactly when the logical address is greater than or equal to its segment length; otherwise it is OK. A request never has OK and fault high together.
- R4: In a cycle with no request on a port, that port's OK and fault flags are both low after the next edge.
- R5: The fetch port uses only the code pair, and the data port uses only the data pair.
- R6: A supervisor-mode load applies from the following cycle. A request in the same cycle as the load still sees the old value.
- R7: A load in user mode changes no register, and err_pulse goes high for exactly the one cycle after it.
- R8: On a faulting request the physical-address output still shows base + logical address.
- R9: cfg_sel encoding: 0 selects the code base, 1 the code length, 2 the data base, 3 the data length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Segment register load strobe |
| cfg_sel | input | 2 | Register select (see R9) |
| cfg_wdata | input | AW | Load value |
| priv_sup | input | 1 | High when the processor is in supervisor mode |
| err_pulse | output | 1 | One-cycle pulse after a user-mode load attempt |
| if_req | input | 1 | Fetch request valid |
| if_laddr | input | AW | Fetch logical address |
| if_paddr | output | AW | Fetch physical address |
| if_ok | output | 1 | Fetch translated within the segment |
| if_fault | output | 1 | Fetch outside the segment |
| dm_req | input | 1 | Data request valid |
| dm_laddr | input | AW | Data logical address |
| dm_paddr | output | AW | Data physical address |
| dm_ok | output | 1 | Data access within the segment |
| dm_fault | output | 1 | Data access outside the segment |

## Verification
The bench builds the block with the default AW of 32. At that width it can drive addresses one below, at and one above each segment length, and a length of all ones. It can also place a base near the top of the range so that the sum wraps past 2^32. Because both ports run in every step, it can show that a fetch faults at an address where a data access is still in range, and the other way round.

// File: rtl/bbx_pkg.sv
// Package: shared constants and the encoding of the register select.
// Assumes two request ports: port 0 is fetch, port 1 is data.
package bbx_pkg;
    localparam int NUM_PORTS = 2;
    localparam int NUM_REGS  = 2 * NUM_PORTS;
    localparam int SEL_W     = $clog2(NUM_REGS);

    // Select value = {port, is_length}
    typedef enum logic [SEL_W-1:0] {
        SEL_CODE_BASE = 2'd0,
        SEL_CODE_LEN  = 2'd1,
        SEL_DATA_BASE = 2'd2,
        SEL_DATA_LEN  = 2'd3
    } seg_sel_e;
endpackage

// File: rtl/bbx_seg_regs.sv
// Module: segment register file with a privilege-gated load port.
// What it does: holds a base and a length for every port and loads one
// register per cycle, but only while supervisor mode is high. A user-mode
// load is dropped and answered with a one-cycle error pulse.
// Assumes: sel = {port, is_length}; synchronous active-low reset clears all.
module bbx_seg_regs
    import bbx_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [SEL_W-1:0]               sel,
    input  logic [AW-1:0]                  wdata,
    input  logic                           sup,
    output logic [NUM_PORTS-1:0][AW-1:0]   base_o,
    output logic [NUM_PORTS-1:0][AW-1:0]   len_o,
    output logic                           err_o
);
    logic [NUM_REGS-1:0][AW-1:0] seg_q;
    logic                        err_q;
    logic                        user_try;

    // Flag a load that arrives outside supervisor mode
    assign user_try = we & ~sup;

    // Register storage and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= user_try;
            if (we && sup) seg_q[sel] <= wdata;
        end
    end

    // Fan the storage out to the ports: even index base, odd index length
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_out
        assign base_o[p] = seg_q[2*p];
        assign len_o[p]  = seg_q[2*p+1];
    end

    assign err_o = err_q;

    // R7: a user-mode load leaves every register as it was
    a_r7_user_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sup) |=> (seg_q == $past(seg_q)));
    // R7: the error pulse follows a user-mode load
    a_r7_err_follows_user_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sup) |=> err_o);
    // R7: no pulse without a user-mode load
    a_r7_err_only_on_user_load: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && !sup) |=> !err_o);
    // R6: a supervisor load lands in the selected register
    a_r6_sup_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sup) |=> (seg_q[$past(sel)] == $past(wdata)));
endmodule

// File: rtl/bbx_seg_xlate.sv
// Module: one translation lane.
// What it does: adds the base to the logical address, compares the address
// with the segment length, and registers the physical address and the
// OK/fault outcome.
// Assumes: the address is presented together with req; the physical address
// register holds its value in cycles without a request.
module bbx_seg_xlate #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] laddr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] seg_len,
    output logic [AW-1:0] paddr_q,
    output logic          ok_q,
    output logic          fault_q
);
    logic [AW-1:0] sum;
    logic          outside;

    // Relocation adder, wraps modulo 2^AW
    assign sum = base + laddr;
    // Limit comparator: at or past the length is outside
    assign outside = (laddr >= seg_len);

    // Output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            ok_q    <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            ok_q    <= req & ~outside;
            fault_q <= req & outside;
            if (req) paddr_q <= sum;
        end
    end

    // R3: one outcome at most
    a_r3_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_q && fault_q));
    // R4: no request, no outcome
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!ok_q && !fault_q));
    // R3: a request always yields an outcome
    a_r3_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (ok_q || fault_q));
endmodule

// File: rtl/seg_translator.sv
// Module: top of the base-and-limit translator.
// What it does: one shared segment register file and one translation lane
// each for fetch (port 0) and data (port 1).
// Assumes: a request's result appears after the next rising edge.
module seg_translator
    import bbx_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          priv_sup,
    output logic          err_pulse,
    input  logic          if_req,
    input  logic [AW-1:0] if_laddr,
    output logic [AW-1:0] if_paddr,
    output logic          if_ok,
    output logic          if_fault,
    input  logic          dm_req,
    input  logic [AW-1:0] dm_laddr,
    output logic [AW-1:0] dm_paddr,
    output logic          dm_ok,
    output logic          dm_fault
);
    logic [NUM_PORTS-1:0][AW-1:0] base_w, len_w, laddr_w, paddr_w;
    logic [NUM_PORTS-1:0]         req_w, ok_w, fault_w;

    // Gather the port-level signals into arrays indexed by port
    assign req_w   = {dm_req, if_req};
    assign laddr_w = {dm_laddr, if_laddr};

    bbx_seg_regs #(.AW(AW)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .sup    (priv_sup),
        .base_o (base_w),
        .len_o  (len_w),
        .err_o  (err_pulse)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
        bbx_seg_xlate #(.AW(AW)) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_w[p]),
            .laddr   (laddr_w[p]),
            .base    (base_w[p]),
            .seg_len (len_w[p]),
            .paddr_q (paddr_w[p]),
            .ok_q    (ok_w[p]),
            .fault_q (fault_w[p])
        );
    end

    // Split the lane results back out to the port pins
    assign if_paddr = paddr_w[0];
    assign if_ok    = ok_w[0];
    assign if_fault = fault_w[0];
    assign dm_paddr = paddr_w[1];
    assign dm_ok    = ok_w[1];
    assign dm_fault = fault_w[1];
endmodule

// File: tb/test_seg_translator.sv
module test_seg_translator;
    localparam int  AW      = 32;
    localparam time CLK_PER = 10ns;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          cfg_we = 1'b0, priv_sup = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          err_pulse;
    logic          if_req = 1'b0, dm_req = 1'b0;
    logic [AW-1:0] if_laddr = '0, dm_laddr = '0;
    logic [AW-1:0] if_paddr, dm_paddr;
    logic          if_ok, if_fault, dm_ok, dm_fault;

    seg_translator #(.AW(AW)) i_seg_translator (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .priv_sup(priv_sup), .err_pulse(err_pulse),
        .if_req(if_req), .if_laddr(if_laddr), .if_paddr(if_paddr),
        .if_ok(if_ok), .if_fault(if_fault),
        .dm_req(dm_req), .dm_laddr(dm_laddr), .dm_paddr(dm_paddr),
        .dm_ok(dm_ok), .dm_fault(dm_fault)
    );

    always #(CLK_PER/2) clk = ~clk;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit finished = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic          ireq, iok, ifl, dreq, dok, dfl, err;
        logic [AW-1:0] ipa, dpa;
        int            due;
    } exp_t;
    exp_t  sb[$];
    string tq[$];
    logic [AW-1:0] mdl[4] = '{default: '0};

    task automatic chk(input bit good, input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_run++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result
    task automatic step(input logic we, input logic [1:0] sel, input logic [AW-1:0] wd,
                        input logic sup, input logic ir, input logic [AW-1:0] ia,
                        input logic dr, input logic [AW-1:0] da, input string tag);
        exp_t e;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd; priv_sup = sup;
        if_req = ir; if_laddr = ia; dm_req = dr; dm_laddr = da;
        e.ireq = ir; e.ipa = mdl[0] + ia;
        e.iok = ir && (ia < mdl[1]); e.ifl = ir && (ia >= mdl[1]);
        e.dreq = dr; e.dpa = mdl[2] + da;
        e.dok = dr && (da < mdl[3]); e.dfl = dr && (da >= mdl[3]);
        e.err = we && !sup;
        e.due = cyc + 1;
        sb.push_back(e); tq.push_back(tag);
        if (we && sup) mdl[sel] = wd;   // R9 select encoding in the model
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: pop the item due this cycle and compare
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t  e;
            string t;
            e = sb.pop_front(); t = tq.pop_front();
            chk(if_ok == e.iok, t, "if_ok", AW'(if_ok), AW'(e.iok));
            chk(if_fault == e.ifl, t, "if_fault", AW'(if_fault), AW'(e.ifl));
            chk(dm_ok == e.dok, t, "dm_ok", AW'(dm_ok), AW'(e.dok));
            chk(dm_fault == e.dfl, t, "dm_fault", AW'(dm_fault), AW'(e.dfl));
            chk(err_pulse == e.err, t, "err_pulse", AW'(err_pulse), AW'(e.err));
            if (e.ireq) chk(if_paddr == e.ipa, t, "if_paddr", if_paddr, e.ipa);
            if (e.dreq) chk(dm_paddr == e.dpa, t, "dm_paddr", dm_paddr, e.dpa);
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of all outputs
        chk({if_ok, if_fault, dm_ok, dm_fault, err_pulse} == 5'b0, "R1", "flags",
            AW'({if_ok, if_fault, dm_ok, dm_fault, err_pulse}), '0);
        chk(if_paddr == '0 && dm_paddr == '0, "R1", "paddr", if_paddr | dm_paddr, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: zero lengths, every request faults
        step(0, 0, 0, 0, 1, 32'h0, 1, 32'h0, "R1");
        // R7: user-mode load ignored, error pulse
        step(1, 2'd1, 32'h1000, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 1, 32'h10, 1, 32'h10, "R7");
        // R9/R6: supervisor loads of all four registers
        step(1, 2'd0, 32'h4000_0000, 1, 0, 0, 0, 0, "R9");
        step(1, 2'd1, 32'h0000_0100, 1, 0, 0, 0, 0, "R9");
        step(1, 2'd2, 32'h8000_0000, 1, 0, 0, 0, 0, "R9");
        step(1, 2'd3, 32'h0000_2000, 1, 0, 0, 0, 0, "R9");
        // R2/R3: just inside each segment
        step(0, 0, 0, 0, 1, 32'hFF, 1, 32'h1FFF, "R2");
        // R3/R8: at the length, faulting, address still shown
        step(0, 0, 0, 0, 1, 32'h100, 1, 32'h2000, "R8");
        step(0, 0, 0, 0, 1, 32'h101, 1, 32'h2001, "R3");
        // R5: same address, fetch outside, data inside
        step(0, 0, 0, 0, 1, 32'h1000, 1, 32'h1000, "R5");
        // R4: idle cycles, no outcome
        idle("R4");
        step(0, 0, 0, 0, 1, 32'h20, 0, 32'h20, "R4");
        // R6: load and request in the same cycle see the old length
        step(1, 2'd1, 32'h2000, 1, 1, 32'h1000, 0, 0, "R6");
        step(0, 0, 0, 0, 1, 32'h1000, 0, 0, "R6");
        // R2: wraparound of the sum past 2^32
        step(1, 2'd2, 32'hFFFF_F000, 1, 0, 0, 0, 0, "R2");
        step(1, 2'd3, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 1, 32'h2000, "R2");
        // R3: all-ones address against an all-ones length faults
        step(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R3");
        step(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFE, "R3");
        // R7: user load to the data length, then probe it
        step(1, 2'd3, 32'h0, 0, 0, 0, 1, 32'h10, "R7");
        step(0, 0, 0, 0, 0, 0, 1, 32'h10, "R7");
        idle("R4");
        idle("R4");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule